// File: doc/BRIEF.md
# Highway and Farm-Road Signal Controller

This block drives the lamps at a crossing where a busy highway meets a lightly used farm road. The highway shows green by default. A single car-present input, brought through a two-stage synchronizer, tells the controller that farm-road traffic is waiting. The farm road gets a green only after the highway has been green for a minimum hold interval. The farm road then keeps its green while cars remain, and for no longer than that same hold interval. Each road passes through a fixed yellow phase before the other road turns green.

The block has four phases: highway go (`PH_HWY_GO`), highway warn (`PH_HWY_WARN`), farm go (`PH_FARM_GO`) and farm warn (`PH_FARM_WARN`). The named transitions are:
- leave-highway: go to warn.
- hand-over: highway warn to farm go.
- release-farm: farm go to warn.
- return: farm warn to highway go.

One restartable interval timer serves every phase. It restarts on each transition and raises a hold flag and a shorter warn flag. Both intervals are parameters counted in clock cycles.

Top module: `tlc_crossing`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the highway lamp shows green and the farm lamp shows red. The timer starts counting from zero.
- R2: The lamp codes are green = 2'b00, yellow = 2'b10 and red = 2'b01. Code 2'b11 never appears. Whichever road is not green or yellow shows red, so at least one lamp is always red.
- R3: Highway green stays on until HOLD_CYC cycles have passed since it was entered and the synchronized car input is high. With car present throughout, highway green lasts exactly HOLD_CYC+1 cycles.
- R4: Highway yellow lasts WARN_CYC+1 cycles, and is then followed by farm green.
- R5: Farm green ends, and farm yellow begins, at the edge after the synchronized car input is low or HOLD_CYC cycles have passed since farm green began.
- R6: Farm yellow lasts WARN_CYC+1 cycles, and is then followed by highway green.
- R7: The timer restarts at every phase change, so each interval counts from the entry of its own phase. With cars present throughout, farm green lasts exactly HOLD_CYC+1 cycles.
- R8: The car input passes through two flip-flops before the controller uses it. A rise of the car input that reaches the synchronizer at a given clock edge, while highway green is past its hold interval, turns the highway lamp yellow at the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| car_waiting | input | 1 | Farm-road car-present sensor, asynchronous |
| hwy_lamp | output | 2 | Highway lamp code (00 green, 10 yellow, 01 red) |
| farm_lamp | output | 2 | Farm-road lamp code (00 green, 10 yellow, 01 red) |

## Verification
The assertions assume a clean reset and a HOLD_CYC larger than WARN_CYC. They also assume that the car input reaches the state machine only through the synchronizer, so the properties refer to the synchronized value and never to the raw pin.

The stimulus changes the car input only at falling clock edges. It covers several patterns:
- the car held high,
- the car held low,
- one-cycle pulses,
- toggles during each phase.

Within these patterns, early requests, farm green cut off by an empty road and farm green cut off by the hold limit all occur.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        PH_HWY_GO    = 2'd0,
        PH_HWY_WARN  = 2'd1,
        PH_FARM_GO   = 2'd2,
        PH_FARM_WARN = 2'd3
    } phase_t;

    localparam logic [1:0] LAMP_GO   = 2'b00;
    localparam logic [1:0] LAMP_WARN = 2'b10;
    localparam logic [1:0] LAMP_STOP = 2'b01;

endpackage

// File: rtl/tlc_sync.sv
module tlc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[i] <= 1'b0;
                end else begin
                    chain[i] <= (i == 0) ? d_async : chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
    parameter int HOLD_CYC = 24,
    parameter int WARN_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic hold_done,
    output logic warn_done
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD_LIM = CW'(HOLD_CYC);
    localparam logic [CW-1:0] WARN_LIM = CW'(WARN_CYC);

    logic [CW-1:0] elapsed;

    // Saturates at the hold limit; the warn limit is below it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (restart) begin
            elapsed <= '0;
        end else if (elapsed != HOLD_LIM) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign hold_done = (elapsed == HOLD_LIM);
    assign warn_done = (elapsed >= WARN_LIM);
endmodule

// File: rtl/tlc_phase_fsm.sv
module tlc_phase_fsm
    import tlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       car,
    input  logic       hold_done,
    input  logic       warn_done,
    output phase_t     phase,
    output logic       restart,
    output logic [1:0] hwy_lamp,
    output logic [1:0] farm_lamp
);
    phase_t phase_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_HWY_GO;
        end else begin
            phase <= phase_nxt;
        end
    end

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_HWY_GO:    if (hold_done && car)  phase_nxt = PH_HWY_WARN;   // leave-highway
            PH_HWY_WARN:  if (warn_done)         phase_nxt = PH_FARM_GO;    // hand-over
            PH_FARM_GO:   if (hold_done || !car) phase_nxt = PH_FARM_WARN;  // release-farm
            PH_FARM_WARN: if (warn_done)         phase_nxt = PH_HWY_GO;     // return
            default:                             phase_nxt = PH_HWY_GO;
        endcase
    end

    assign restart = (phase_nxt != phase);

    always_comb begin
        hwy_lamp  = LAMP_STOP;
        farm_lamp = LAMP_STOP;
        unique case (phase)
            PH_HWY_GO:    hwy_lamp  = LAMP_GO;
            PH_HWY_WARN:  hwy_lamp  = LAMP_WARN;
            PH_FARM_GO:   farm_lamp = LAMP_GO;
            PH_FARM_WARN: farm_lamp = LAMP_WARN;
            default:      hwy_lamp  = LAMP_STOP;
        endcase
    end
endmodule

// File: rtl/tlc_crossing.sv
module tlc_crossing
    import tlc_pkg::*;
#(
    parameter int HOLD_CYC    = 24,
    parameter int WARN_CYC    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       car_waiting,
    output logic [1:0] hwy_lamp,
    output logic [1:0] farm_lamp
);
    logic   car_sync;
    logic   hold_done;
    logic   warn_done;
    logic   restart;
    phase_t phase;

    tlc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (car_waiting),
        .q_sync  (car_sync)
    );

    tlc_interval_timer #(.HOLD_CYC(HOLD_CYC), .WARN_CYC(WARN_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .hold_done (hold_done),
        .warn_done (warn_done)
    );

    tlc_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .car       (car_sync),
        .hold_done (hold_done),
        .warn_done (warn_done),
        .phase     (phase),
        .restart   (restart),
        .hwy_lamp  (hwy_lamp),
        .farm_lamp (farm_lamp)
    );
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker
    import tlc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] hwy_lamp,
    input logic [1:0] farm_lamp,
    input phase_t     phase,
    input logic       hold_done,
    input logic       warn_done,
    input logic       car_sync
);
    p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_lamp != 2'b11) && (farm_lamp != 2'b11));

    p_one_red_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_lamp == LAMP_STOP) || (farm_lamp == LAMP_STOP));

    p_hwy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_lamp == LAMP_GO && !hold_done) |=> (hwy_lamp == LAMP_GO));

    p_hwy_warn_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_lamp == LAMP_WARN && !warn_done) |=> (hwy_lamp == LAMP_WARN));

    p_farm_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (farm_lamp == LAMP_GO && !car_sync) |=> (farm_lamp == LAMP_WARN));

    p_farm_warn_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (farm_lamp == LAMP_WARN && warn_done) |=> (hwy_lamp == LAMP_GO));

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> (!warn_done && !hold_done));
endmodule

bind tlc_crossing tlc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hwy_lamp  (hwy_lamp),
    .farm_lamp (farm_lamp),
    .phase     (phase),
    .hold_done (hold_done),
    .warn_done (warn_done),
    .car_sync  (car_sync)
);

// File: tb/tlc_crossing_bench.sv
module tlc_crossing_bench;
    localparam int HOLD = 24;
    localparam int WARN = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       car_waiting = 1'b0;
    logic [1:0] hwy_lamp;
    logic [1:0] farm_lamp;

    int vectors = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tlc_crossing #(.HOLD_CYC(HOLD), .WARN_CYC(WARN)) u_tlc_crossing (
        .clk         (clk),
        .rst_n       (rst_n),
        .car_waiting (car_waiting),
        .hwy_lamp    (hwy_lamp),
        .farm_lamp   (farm_lamp)
    );

    // Behavioural reference: 0 hwy green, 1 hwy yellow, 2 farm green, 3 farm yellow
    int m_ph;
    int m_age;
    bit m_q1;
    bit m_q2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_age = 0; m_q1 = 0; m_q2 = 0;
        end else begin
            int nx;
            nx = m_ph;
            if (m_ph == 0 && m_age >= HOLD && m_q2) nx = 1;
            if (m_ph == 1 && m_age >= WARN) nx = 2;
            if (m_ph == 2 && (m_age >= HOLD || !m_q2)) nx = 3;
            if (m_ph == 3 && m_age >= WARN) nx = 0;
            if (nx != m_ph) m_age = 0;
            else if (m_age < HOLD) m_age = m_age + 1;
            m_ph = nx;
            m_q2 = m_q1;
            m_q1 = car_waiting;
        end
    end

    function automatic logic [1:0] exp_hwy(int ph);
        return (ph == 0) ? 2'b00 : (ph == 1) ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [1:0] exp_farm(int ph);
        return (ph == 2) ? 2'b00 : (ph == 3) ? 2'b10 : 2'b01;
    endfunction

    function automatic string req_of(int ph);
        case (ph)
            0: return "R3";
            1: return "R4";
            2: return "R5/R7";
            default: return "R6";
        endcase
    endfunction

    // Per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            vectors++;
            if (hwy_lamp !== exp_hwy(m_ph) || farm_lamp !== exp_farm(m_ph)) begin
                errors++;
                $display("FAIL %s: lamps hwy=%b farm=%b expected hwy=%b farm=%b",
                         req_of(m_ph), hwy_lamp, farm_lamp, exp_hwy(m_ph), exp_farm(m_ph));
            end
            if (hwy_lamp == 2'b11 || farm_lamp == 2'b11
                || (hwy_lamp != 2'b01 && farm_lamp != 2'b01)) begin
                errors++;
                $display("FAIL R2: hwy=%b farm=%b expected a legal code and one red",
                         hwy_lamp, farm_lamp);
            end
        end
    end

    task automatic check(string req, logic [1:0] got, logic [1:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic check_int(string req, int got, int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_car(bit v);
        @(negedge clk);
        car_waiting = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        car_waiting = 1'b0;
        idle(2);
        check("R1", hwy_lamp, 2'b00);
        check("R1", farm_lamp, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", hwy_lamp, 2'b00);
        check("R1", farm_lamp, 2'b01);
    endtask

    initial begin
        int len;
        do_reset();

        // No car: highway keeps green (R3)
        idle(60);
        check("R3", hwy_lamp, 2'b00);

        // R8: car rises after hold elapsed; yellow at third edge
        car_waiting = 1'b1;
        @(negedge clk); check("R8", hwy_lamp, 2'b00);
        @(negedge clk); check("R8", hwy_lamp, 2'b00);
        @(negedge clk); check("R8", hwy_lamp, 2'b10);

        // R7: steady car gives maximum farm green of HOLD+1 cycles
        while (farm_lamp != 2'b00) @(negedge clk);
        len = 0;
        while (farm_lamp == 2'b00) begin len++; @(negedge clk); end
        check_int("R7", len, HOLD + 1);
        check("R6", farm_lamp, 2'b10);

        // R3: steady car after return; highway green lasts HOLD+1
        while (hwy_lamp != 2'b00) @(negedge clk);
        len = 0;
        while (hwy_lamp == 2'b00) begin len++; @(negedge clk); end
        check_int("R3", len, HOLD + 1);

        // R5: car leaves during farm green -> early release
        while (farm_lamp != 2'b00) @(negedge clk);
        idle(3);
        car_waiting = 1'b0;
        idle(4);
        check("R5", farm_lamp, 2'b10);
        idle(40);

        // One-cycle pulse early in highway green, then late pulse
        do_reset();
        idle(3);
        set_car(1); set_car(0);
        idle(40);
        check("R3", hwy_lamp, 2'b00);
        set_car(1); set_car(0);
        idle(60);

        // Toggling car through all phases
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            car_waiting = ((k % 7) < 4) || ((k % 53) == 0);
        end
        car_waiting = 1'b0;
        idle(80);
        check("R1", hwy_lamp, 2'b00);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule